// File: doc/BRIEF.md
# Dual-Port Bit-Plane Column with Erasure Flagging

This block is one bit-plane column of a dual-port memory assembled from single-ported storage. The column holds 2^(BIN_BITS+OFS_BITS) bits. These bits are divided into 2^BIN_BITS bins, and each bin holds 2^OFS_BITS bits. Each port presents a bin index, an offset inside the bin, an enable and a write strobe. Port A also presents a write data bit. When the two ports address different bins, both are served in the same cycle. When they address the same bin at different offsets, the bin serves port A only. In that case port B's bit is dropped and an erasure flag marks that this column lost port B's bit. A word-level corrector placed outside the column can then rebuild the missing bit.

Every bin picks its owner each cycle from a decode state. The bin-owner states are:
- `BIN_IDLE`: no port is selecting the bin.
- `BIN_A`: only port A is selecting the bin.
- `BIN_B`: only port B is selecting the bin.
- `BIN_SHARED`: both ports select the same bin at the same offset.
- `BIN_CLASH`: both ports select the same bin at different offsets.

The state is chosen again every cycle from the two selects and the offset comparison, so any state can follow any other. Read data and the erasure flag are registered and appear one clock after the request. Only port A can write. A read of the cell being written returns the new data.

Top module: `erasure_bin_column`

## Requirements
- R1: After reset, `a_rdata`, `b_rdata` and `b_erase` are 0, and every storage bit reads as 0.
- R2: A port A write (`a_en`=1, `a_we`=1) stores `a_wdata` at address {`a_bin`,`a_ofs`}. A later port A read of that address returns it on `a_rdata` one clock after the request.
- R3: When both ports are enabled and `a_bin` differs from `b_bin`, both reads are served in the same cycle, each with its own stored bit, and `b_erase` stays 0.
- R4: When both ports are enabled with equal bins and different offsets, port A is served. One clock later `b_erase` is 1 and `b_rdata` is 0.
- R5: A port A write that clashes in a bin with a port B read still stores its data, and port B is flagged as erased.
- R6: When both ports are enabled with equal bin and equal offset, and port B is reading, `b_rdata` equals `a_rdata` one clock later and `b_erase` is 0. If port A is writing, both outputs carry the write data.
- R7: `b_we` has no effect on storage: a port B access with `b_we`=1 behaves as a read and leaves every stored bit unchanged.
- R8: A port that is not enabled gets 0 on its read output on the following clock. When `b_en` is 0, `b_erase` is 0 on the following clock.
- R9: `b_erase` is held for exactly the one cycle that follows a clashing request. It is registered in the same cycle as the data it qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write strobe (1 = write) |
| a_bin | input | BIN_BITS | Port A bin index |
| a_ofs | input | OFS_BITS | Port A offset inside the bin |
| a_wdata | input | 1 | Port A write data bit |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write strobe (ignored) |
| b_bin | input | BIN_BITS | Port B bin index |
| b_ofs | input | OFS_BITS | Port B offset inside the bin |
| a_rdata | output | 1 | Port A read bit, one clock after the request |
| b_rdata | output | 1 | Port B read bit, one clock after the request |
| b_erase | output | 1 | Port B bit lost to a same-bin clash |

## Verification
The bench builds the column with BIN_BITS=3 and OFS_BITS=3, which gives 8 bins of 8 bits. At this size the whole 64-bit array can be filled and read back. It also allows clash cases at the lowest bin and at the highest bin with their extreme offsets. Every bin-owner state can then be reached, including a shared cell that is being written in the same cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    typedef enum logic [2:0] {
        BIN_IDLE,
        BIN_A,
        BIN_B,
        BIN_SHARED,
        BIN_CLASH
    } owner_t;
endpackage

// File: rtl/ebc_bin.sv
module ebc_bin
    import ebc_pkg::*;
#(
    parameter int OFS_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_a,
    input  logic                sel_b,
    input  logic                a_we,
    input  logic [OFS_BITS-1:0] a_ofs,
    input  logic [OFS_BITS-1:0] b_ofs,
    input  logic                a_wdata,
    output logic                bit_out,
    output owner_t              owner
);
    localparam int DEPTH = 1 << OFS_BITS;

    logic [DEPTH-1:0]    cells;
    logic [OFS_BITS-1:0] ofs_mux;
    logic                wr;

    always_comb begin
        owner = BIN_IDLE;
        unique case ({sel_a, sel_b})
            2'b00: owner = BIN_IDLE;
            2'b10: owner = BIN_A;
            2'b01: owner = BIN_B;
            2'b11: owner = (a_ofs == b_ofs) ? BIN_SHARED : BIN_CLASH;
        endcase
    end

    always_comb begin
        ofs_mux = (owner == BIN_B) ? b_ofs : a_ofs;
        wr      = a_we && (owner == BIN_A || owner == BIN_SHARED || owner == BIN_CLASH);
        bit_out = wr ? a_wdata : cells[ofs_mux];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (wr) begin
            cells[a_ofs] <= a_wdata;
        end
    end

    // R7
    b_never_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_a && a_we) |=> $stable(cells));
endmodule

// File: rtl/erasure_bin_column.sv
module erasure_bin_column
    import ebc_pkg::*;
#(
    parameter int BIN_BITS = 3,
    parameter int OFS_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_en,
    input  logic                a_we,
    input  logic [BIN_BITS-1:0] a_bin,
    input  logic [OFS_BITS-1:0] a_ofs,
    input  logic                a_wdata,
    input  logic                b_en,
    input  logic                b_we,
    input  logic [BIN_BITS-1:0] b_bin,
    input  logic [OFS_BITS-1:0] b_ofs,
    output logic                a_rdata,
    output logic                b_rdata,
    output logic                b_erase
);
    localparam int NBINS = 1 << BIN_BITS;

    logic [NBINS-1:0] bit_vec;
    owner_t           owner_vec [NBINS];
    owner_t           b_owner;
    logic             b_served;
    logic             b_lost;
    logic             b_we_unused;

    assign b_we_unused = b_we;

    for (genvar i = 0; i < NBINS; i++) begin : g_bin
        ebc_bin #(.OFS_BITS(OFS_BITS)) u_bin (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_a   (a_en && (a_bin == BIN_BITS'(i))),
            .sel_b   (b_en && (b_bin == BIN_BITS'(i))),
            .a_we    (a_we),
            .a_ofs   (a_ofs),
            .b_ofs   (b_ofs),
            .a_wdata (a_wdata),
            .bit_out (bit_vec[i]),
            .owner   (owner_vec[i])
        );
    end

    always_comb begin
        b_owner  = owner_vec[b_bin];
        b_served = 1'b0;
        b_lost   = 1'b0;
        if (b_en) begin
            unique case (b_owner)
                BIN_B, BIN_SHARED: b_served = 1'b1;
                BIN_CLASH:         b_lost   = 1'b1;
                default:           b_served = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= 1'b0;
            b_rdata <= 1'b0;
            b_erase <= 1'b0;
        end else begin
            a_rdata <= a_en && bit_vec[a_bin];
            b_rdata <= b_served && bit_vec[b_bin];
            b_erase <= b_lost;
        end
    end

    // R4
    erase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_erase |-> $past(a_en && b_en && a_bin == b_bin && a_ofs != b_ofs));
    // R4
    erase_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_erase |-> !b_rdata);
    // R6
    shared_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && a_bin == b_bin && a_ofs == b_ofs) |=> (b_rdata == a_rdata && !b_erase));
    // R8
    b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> (!b_erase && !b_rdata));
endmodule

// File: tb/tb_erasure_bin_column.sv
`timescale 1ns/1ps
module tb_erasure_bin_column;
    localparam int BB = 3;
    localparam int OB = 3;
    localparam int AW = BB + OB;
    localparam int N  = 1 << AW;

    logic clk = 0;
    logic rst_n = 0;
    logic a_en = 0, a_we = 0, a_wdata = 0, b_en = 0, b_we = 0;
    logic [BB-1:0] a_bin = 0, b_bin = 0;
    logic [OB-1:0] a_ofs = 0, b_ofs = 0;
    logic a_rdata, b_rdata, b_erase;
    logic model [N];
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    erasure_bin_column #(.BIN_BITS(BB), .OFS_BITS(OB)) dut (
        .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_we(a_we), .a_bin(a_bin), .a_ofs(a_ofs),
        .a_wdata(a_wdata), .b_en(b_en), .b_we(b_we), .b_bin(b_bin), .b_ofs(b_ofs),
        .a_rdata(a_rdata), .b_rdata(b_rdata), .b_erase(b_erase));

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one request cycle; outputs are sampled at the next falling edge
    task automatic step(input logic ae, input logic awe, input logic [AW-1:0] aadr, input logic awd,
                        input logic be, input logic bwe, input logic [AW-1:0] badr);
        {a_en, a_we, a_wdata, b_en, b_we} = {ae, awe, awd, be, bwe};
        {a_bin, a_ofs} = aadr;
        {b_bin, b_ofs} = badr;
        @(negedge clk);
        if (ae && awe) model[aadr] = awd;
        {a_en, a_we, b_en, b_we} = 4'b0;
    endtask

    function automatic logic pat(int adr);
        return logic'(((adr * 5 + 3) >> 2) & 1) ^ logic'(adr[0]);
    endfunction

    task automatic t_reset;
        chk("R1 a_rdata", a_rdata, 0);
        chk("R1 b_rdata", b_rdata, 0);
        chk("R1 b_erase", b_erase, 0);
        for (int i = 0; i < N; i += 9) begin
            step(1, 0, AW'(i), 0, 1, 0, AW'(N - 1 - i));
            chk("R1 cleared A", a_rdata, 0);
        end
    endtask

    task automatic t_fill_read;
        for (int i = 0; i < N; i++) step(1, 1, AW'(i), pat(i), 0, 0, 0);
        for (int i = 0; i < N; i++) begin
            step(1, 0, AW'(i), 0, 0, 0, 0);
            chk("R2 A readback", a_rdata, model[i]);
        end
    endtask

    task automatic t_diff_bins;
        for (int i = 0; i < N; i += 7) begin
            logic [AW-1:0] ad = AW'(i);
            logic [AW-1:0] bd = {ad[AW-1:OB] + BB'(3), ad[OB-1:0] ^ OB'(5)};
            step(1, 0, ad, 0, 1, 0, bd);
            chk("R3 A data", a_rdata, model[ad]);
            chk("R3 B data", b_rdata, model[bd]);
            chk("R3 no erase", b_erase, 0);
        end
    endtask

    task automatic t_clash_read;
        step(1, 0, {3'd0, 3'd0}, 0, 1, 0, {3'd0, 3'd7});
        chk("R4 A served", a_rdata, model[0]);
        chk("R4 erase", b_erase, 1);
        chk("R4 B zero", b_rdata, 0);
        step(0, 0, 0, 0, 1, 0, {3'd7, 3'd7});
        chk("R9 erase one cycle", b_erase, 0);
        chk("R9 B data", b_rdata, model[N-1]);
    endtask

    task automatic t_clash_write;
        logic nv = ~model[{3'd7, 3'd2}];
        step(1, 1, {3'd7, 3'd2}, nv, 1, 0, {3'd7, 3'd5});
        chk("R5 erase", b_erase, 1);
        chk("R5 A write echo", a_rdata, nv);
        step(1, 0, {3'd7, 3'd2}, 0, 0, 0, 0);
        chk("R5 write kept", a_rdata, nv);
    endtask

    task automatic t_shared;
        step(1, 0, {3'd4, 3'd1}, 0, 1, 0, {3'd4, 3'd1});
        chk("R6 B equals A", b_rdata, model[{3'd4, 3'd1}]);
        chk("R6 no erase", b_erase, 0);
        step(1, 1, {3'd4, 3'd1}, ~model[{3'd4, 3'd1}], 1, 0, {3'd4, 3'd1});
        chk("R6 B sees write", b_rdata, model[{3'd4, 3'd1}]);
        chk("R6 A sees write", a_rdata, model[{3'd4, 3'd1}]);
    endtask

    task automatic t_bwrite;
        step(0, 0, 0, 0, 1, 1, {3'd2, 3'd6});
        chk("R7 B write as read", b_rdata, model[{3'd2, 3'd6}]);
        step(1, 0, {3'd2, 3'd6}, 0, 0, 0, 0);
        chk("R7 cell unchanged", a_rdata, model[{3'd2, 3'd6}]);
    endtask

    task automatic t_idle;
        logic [AW-1:0] one = AW'(0);
        for (int i = 0; i < N; i++) if (model[i]) one = AW'(i);
        step(1, 0, one, 0, 0, 0, one);
        chk("R8 A data", a_rdata, 1);
        chk("R8 B idle zero", b_rdata, 0);
        chk("R8 B idle no erase", b_erase, 0);
        step(0, 0, one, 0, 1, 0, one);
        chk("R8 A idle zero", a_rdata, 0);
        chk("R8 B alone", b_rdata, 1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_fill_read;
        t_diff_bins;
        t_clash_read;
        t_clash_write;
        t_shared;
        t_bwrite;
        t_idle;
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule